// File: doc/BRIEF.md
# Instruction Prefetch Queue

This block fetches instruction bytes ahead of the execution side and holds them in a small first-in-first-out store. It keeps a code segment and a 16-bit instruction offset. From these it forms a 20-bit physical fetch address and reads one byte at a time over a request/acknowledge memory interface. Fetching runs on its own whenever there is room, so the fetch of the next bytes overlaps the execution side's consumption of earlier ones.

The execution side takes bytes through a valid/ready port, at most one per cycle, oldest first. When the program changes flow, a one-cycle redirect pulse loads a new segment and offset. The same pulse discards every held byte and abandons any read still outstanding, and fetching restarts at the new location.

Top module: `pfq_unit`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `mem_req` and `out_valid` are low. The first fetch then goes to segment `RST_SEG` at offset `RST_OFF`.
- R2: The fetch address is (segment × 16 + offset) modulo 2^20, so segment 0xFFFF with offset 0x0020 gives 0x00010.
- R3: Once raised, `mem_req` stays high with `mem_addr` unchanged until a cycle in which `mem_ack` is high or a redirect occurs.
- R4: Every accepted read (`mem_req` and `mem_ack` both high, no redirect) advances the offset by one. Offset 0xFFFF is followed by 0x0000, and the segment stays the same.
- R5: Bytes leave in the order they were fetched, and at most `DEPTH` (6) are held.
- R6: A read is requested only when the queue, counting the read in flight, has a free entry. With the consumer stalled, exactly `DEPTH` reads complete, and `mem_req` then stays low.
- R7: `out_valid` is high exactly when at least one byte is held, and `out_byte` is then the oldest byte.
- R8: A pop and an accepted read in the same cycle leave the number of held bytes unchanged.
- R9: `out_ready` while the queue is empty has no effect: `out_valid` stays low and no byte is lost or invented.
- R10: A redirect empties the queue and drops any outstanding read, and any handshake on `out_ready` in that cycle is discarded. In the next cycle `out_valid` and `mem_req` are low. The cycle after that, the request goes to the new segment and offset.
- R11: A `mem_ack` that arrives while `mem_req` is low, or in a redirect cycle, is ignored: no byte is queued and the offset does not move.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| redir_valid | input | 1 | Pulse: flush and jump to `redir_seg:redir_off` |
| redir_seg | input | 16 | New code segment |
| redir_off | input | 16 | New instruction offset |
| mem_req | output | 1 | Byte read request |
| mem_addr | output | 20 | Physical address of the requested byte |
| mem_ack | input | 1 | Read completes this cycle, data valid |
| mem_data | input | 8 | Byte returned with `mem_ack` |
| out_valid | output | 1 | A queued byte is available |
| out_byte | output | 8 | Oldest queued byte |
| out_ready | input | 1 | Execution side takes the byte this cycle |

## Verification
The fetch-and-deliver path is tried under five traffic patterns. A zero-latency memory with an always-ready consumer shows back-to-back fetching and simultaneous push and pop. A stalled consumer with slow memory shows the six-entry cap and the in-flight accounting. A drain with memory silenced shows empty pops being ignored. Random latency with stray acknowledges separates real completions from spurious ones. Random redirects, aimed at the 0xFFFF offset wrap, the 20-bit address truncation corner and at cycles that coincide with an acknowledge, show that a flush discards stale data and that fetching restarts at the right address.

// File: rtl/pfq_pkg.sv
package pfq_pkg;

  localparam int OFF_W  = 16;
  localparam int SEG_W  = 16;
  localparam int PA_W   = 20;
  localparam int BYTE_W = 8;

  // segment shifted left by four plus offset, carry beyond bit 19 discarded
  function automatic logic [PA_W-1:0] phys_addr(input logic [SEG_W-1:0] seg,
                                                input logic [OFF_W-1:0] off);
    logic [PA_W-1:0] base;
    logic [PA_W-1:0] disp;
    base = {seg, 4'h0};
    disp = {{(PA_W-OFF_W){1'b0}}, off};
    return base + disp;
  endfunction

  // offset step inside one 64 KB segment
  function automatic logic [OFF_W-1:0] next_off(input logic [OFF_W-1:0] off);
    return off + 1'b1;
  endfunction

endpackage

// File: rtl/pfq_ptr.sv
module pfq_ptr
  import pfq_pkg::*;
#(
  parameter logic [SEG_W-1:0] RST_SEG = 16'hFFFF,
  parameter logic [OFF_W-1:0] RST_OFF = 16'h0000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic [SEG_W-1:0] new_seg,
  input  logic [OFF_W-1:0] new_off,
  input  logic             advance,
  output logic [OFF_W-1:0] cur_off,
  output logic [PA_W-1:0]  fetch_addr
);

  logic [SEG_W-1:0] seg_q;
  logic [OFF_W-1:0] off_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      seg_q <= RST_SEG;
      off_q <= RST_OFF;
    end else if (flush) begin
      seg_q <= new_seg;
      off_q <= new_off;
    end else if (advance) begin
      off_q <= next_off(off_q);
    end
  end

  assign cur_off    = off_q;
  assign fetch_addr = phys_addr(seg_q, off_q);

endmodule

// File: rtl/pfq_fifo.sv
module pfq_fifo #(
  parameter int DEPTH = 6,
  parameter int W     = 8,
  localparam int CW   = $clog2(DEPTH + 1),
  localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          push,
  input  logic [W-1:0]  push_data,
  input  logic          pop,
  output logic [W-1:0]  head,
  output logic [CW-1:0] count,
  output logic [CW-1:0] count_n
);

  logic [W-1:0]  store [DEPTH];
  logic [PW-1:0] wr_ptr;
  logic [PW-1:0] rd_ptr;

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_comb begin
    if (flush) count_n = '0;
    else       count_n = count + CW'(push) - CW'(pop);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else if (flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) wr_ptr <= bump(wr_ptr);
      if (pop)  rd_ptr <= bump(rd_ptr);
      count <= count_n;
    end
  end

  always_ff @(posedge clk) begin
    if (push && !flush) store[wr_ptr] <= push_data;
  end

  assign head = store[rd_ptr];

endmodule

// File: rtl/pfq_ctl.sv
module pfq_ctl #(
  parameter int DEPTH = 6,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          mem_ack,
  input  logic [CW-1:0] count_n,
  output logic          busy,
  output logic          fetch_done
);

  // room check uses next-cycle occupancy, so the read about to be issued is
  // already counted against the free space
  logic room_after;
  assign room_after = (count_n < CW'(DEPTH));
  assign fetch_done = busy && mem_ack && !flush;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0;
    end else if (flush) begin
      busy <= 1'b0;
    end else if (!busy || mem_ack) begin
      busy <= room_after;
    end
  end

endmodule

// File: rtl/pfq_unit.sv
module pfq_unit
  import pfq_pkg::*;
#(
  parameter int               DEPTH   = 6,
  parameter logic [SEG_W-1:0] RST_SEG = 16'hFFFF,
  parameter logic [OFF_W-1:0] RST_OFF = 16'h0000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              redir_valid,
  input  logic [SEG_W-1:0]  redir_seg,
  input  logic [OFF_W-1:0]  redir_off,
  output logic              mem_req,
  output logic [PA_W-1:0]   mem_addr,
  input  logic              mem_ack,
  input  logic [BYTE_W-1:0] mem_data,
  output logic              out_valid,
  output logic [BYTE_W-1:0] out_byte,
  input  logic              out_ready
);

  localparam int CW = $clog2(DEPTH + 1);

  // named internal events, observed by the bound checker
  logic          flush;
  logic          fetch_done;
  logic          pop_fire;
  logic [CW-1:0] q_count;
  logic [CW-1:0] q_count_n;
  logic [OFF_W-1:0] cur_off;
  logic          busy;

  assign flush     = redir_valid;
  assign out_valid = (q_count != '0);
  assign pop_fire  = out_valid && out_ready && !flush;
  assign mem_req   = busy;

  pfq_ptr #(.RST_SEG(RST_SEG), .RST_OFF(RST_OFF)) u_ptr (
    .clk        (clk),
    .rst_n      (rst_n),
    .flush      (flush),
    .new_seg    (redir_seg),
    .new_off    (redir_off),
    .advance    (fetch_done),
    .cur_off    (cur_off),
    .fetch_addr (mem_addr)
  );

  pfq_fifo #(.DEPTH(DEPTH), .W(BYTE_W)) u_fifo (
    .clk       (clk),
    .rst_n     (rst_n),
    .flush     (flush),
    .push      (fetch_done),
    .push_data (mem_data),
    .pop       (pop_fire),
    .head      (out_byte),
    .count     (q_count),
    .count_n   (q_count_n)
  );

  pfq_ctl #(.DEPTH(DEPTH)) u_ctl (
    .clk        (clk),
    .rst_n      (rst_n),
    .flush      (flush),
    .mem_ack    (mem_ack),
    .count_n    (q_count_n),
    .busy       (busy),
    .fetch_done (fetch_done)
  );

endmodule

// File: rtl/pfq_unit_chk.sv
module pfq_unit_chk #(
  parameter int DEPTH = 6,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          mem_req,
  input logic [19:0]   mem_addr,
  input logic          mem_ack,
  input logic          out_valid,
  input logic          out_ready,
  input logic          flush,
  input logic          fetch_done,
  input logic          pop_fire,
  input logic [CW-1:0] q_count,
  input logic [15:0]   cur_off
);

  p_req_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack && !flush |=> mem_req && $stable(mem_addr));

  p_off_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_done |=> cur_off == 16'($past(cur_off) + 16'd1));

  p_room_r6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> q_count < CW'(DEPTH));

  p_no_overflow_r5: assert property (@(posedge clk) disable iff (!rst_n)
    q_count <= CW'(DEPTH));

  p_pushpop_r8: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_done && pop_fire |=> $stable(q_count));

  p_empty_pop_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid && out_ready && !fetch_done |=> !out_valid);

  p_flush_r10: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> !out_valid && !mem_req);

  p_stray_ack_r11: assert property (@(posedge clk) disable iff (!rst_n)
    mem_ack && !mem_req && !flush |=> $stable(cur_off));

endmodule

bind pfq_unit pfq_unit_chk #(.DEPTH(DEPTH)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .mem_req    (mem_req),
  .mem_addr   (mem_addr),
  .mem_ack    (mem_ack),
  .out_valid  (out_valid),
  .out_ready  (out_ready),
  .flush      (flush),
  .fetch_done (fetch_done),
  .pop_fire   (pop_fire),
  .q_count    (q_count),
  .cur_off    (cur_off)
);

// File: tb/pfq_unit_test.sv
module pfq_unit_test;

  localparam int CLK_PERIOD = 10;
  localparam int DEPTH      = 6;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        redir_valid = 1'b0;
  logic [15:0] redir_seg = '0;
  logic [15:0] redir_off = '0;
  logic        mem_req;
  logic [19:0] mem_addr;
  logic        mem_ack = 1'b0;
  logic [7:0]  mem_data = '0;
  logic        out_valid;
  logic [7:0]  out_byte;
  logic        out_ready = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pfq_unit #(.DEPTH(DEPTH)) uut (
    .clk(clk), .rst_n(rst_n),
    .redir_valid(redir_valid), .redir_seg(redir_seg), .redir_off(redir_off),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_ack(mem_ack), .mem_data(mem_data),
    .out_valid(out_valid), .out_byte(out_byte), .out_ready(out_ready)
  );

  int n_chk  = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  // reference state: plain integers and a queue
  logic [7:0] mq[$];
  bit mbusy;
  int mseg, moff;

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [19:0] ref_pa(input int seg, input int off);
    return 20'((seg * 16 + off) % 1048576);
  endfunction

  function automatic logic [7:0] data_at(input logic [19:0] a);
    return 8'(a * 7) ^ a[19:12] ^ 8'h5A;
  endfunction

  task automatic step(input int p_ready, input int p_ack, input int p_stray, input int p_redir);
    bit rd, got, pop;
    int tseg, toff;
    // compare outputs settled after the last rising edge
    check("R3/R6", "mem_req", 32'(mem_req), 32'(mbusy));
    if (mbusy) check("R2/R4/R11", "mem_addr", 32'(mem_addr), 32'(ref_pa(mseg, moff)));
    check("R7/R9/R10", "out_valid", 32'(out_valid), 32'(mq.size() != 0));
    if (mq.size() != 0) check("R5/R8", "out_byte", 32'(out_byte), 32'(mq[0]));
    // drive this cycle's inputs
    out_ready = (($urandom % 100) < p_ready);
    rd = (($urandom % 100) < p_redir);
    tseg = 0; toff = 0;
    if (rd) begin
      case ($urandom % 4)
        0: begin tseg = 16'h1234; toff = 16'hFFFE; end
        1: begin tseg = 16'hFFFF; toff = 16'h0020; end
        2: begin tseg = int'($urandom % 65536); toff = int'($urandom % 65536); end
        default: begin tseg = 0; toff = 0; end
      endcase
    end
    redir_valid = rd;
    redir_seg   = 16'(tseg);
    redir_off   = 16'(toff);
    mem_ack  = mem_req ? (($urandom % 100) < p_ack) : (($urandom % 100) < p_stray);
    mem_data = mem_req ? data_at(mem_addr) : 8'hEE;
    // advance the reference model with the same inputs
    if (rd) begin
      mq.delete(); mbusy = 1'b0; mseg = tseg; moff = toff;   // R10
    end else begin
      got = mbusy && mem_ack;                                 // R11: stray ack ignored
      pop = out_ready && (mq.size() != 0);                    // R9: empty pop ignored
      if (pop) void'(mq.pop_front());
      if (got) begin
        mq.push_back(data_at(ref_pa(mseg, moff)));
        moff = (moff + 1) % 65536;                            // R4
      end
      if (!mbusy || mem_ack) mbusy = (mq.size() < DEPTH);     // R6
    end
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic run(input int n, input int p_ready, input int p_ack,
                     input int p_stray, input int p_redir);
    for (int i = 0; i < n; i++) step(p_ready, p_ack, p_stray, p_redir);
  endtask

  initial begin
    void'($urandom(7));
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1", "mem_req in reset", 32'(mem_req), 32'd0);
    check("R1", "out_valid in reset", 32'(out_valid), 32'd0);
    rst_n = 1'b1;
    mbusy = 1'b0; mseg = 16'hFFFF; moff = 0;
    // first cycle after reset, then first fetch at 0xFFFF0
    check("R1", "mem_req after reset", 32'(mem_req), 32'd0);
    step(0, 0, 0, 0);
    check("R1", "first fetch address", 32'(mem_addr), 32'h000FFFF0);
    run(150, 100, 100, 0, 0);     // back-to-back, push and pop together (R8)
    run(60, 0, 60, 0, 0);         // consumer stalled: cap at six (R6)
    check("R6", "request low when full", 32'(mem_req), 32'd0);
    check("R5", "six bytes held", 32'(mq.size()), 32'(DEPTH));
    run(60, 100, 0, 0, 0);        // drain, then pops on empty (R9)
    check("R9", "empty after drain", 32'(out_valid), 32'd0);
    run(1500, 50, 40, 30, 0);     // random latency with stray acks (R11)
    run(1500, 60, 50, 30, 4);     // random redirects (R10, R2, R4)
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule